// File: doc/BRIEF.md
# Bus-Side Transceiver Supervisor

This block is the digital supervisor on the bus side of an isolated CAN physical-layer transceiver. It takes the transmit bit from the protocol controller, a flag that marks that bit as undriven, two supply-present flags and a receive comparator result. From these it produces the commands for the analog line driver and the receive bit returned to the controller. The line driver itself, the comparators and the regulator are outside this block.

It adds two protections around the plain truth table. The first is a bus-power status flag. It is active low, asserts after a short settling delay once bus power appears, and releases only after a much longer delay once bus power is lost. The second is a thermal cutoff. A digital die-temperature code in whole degrees Celsius turns the driver off at a hot threshold, and the driver comes back only once the code has fallen to a lower threshold. The receive path keeps working while the driver is cut off. The two delays are set by a reference-clock frequency parameter and two time parameters. All outputs are registered, so they follow the inputs sampled at the previous rising clock edge.

Top module: `txsup_top`

## Requirements
- R1: With both supplies present, the die cool and the transmit bit low and not floating, `drv_en` and `drv_dom` are both 1 one cycle later.
- R2: A transmit bit that is high, or marked floating, gives `drv_dom` = 0 one cycle later, which leaves the bus recessive with the driver pins at high impedance. `drv_dom` is never 1 while `drv_en` is 0.
- R3: While `logic_ok` is 0, `drv_en` and `drv_dom` are 0 one cycle later, whatever the transmit bit is.
- R4: While `bus_ok` is 0, `drv_en` and `drv_dom` are 0 one cycle later.
- R5: One cycle after the inputs are sampled, `rxd_out` is 0 when `rx_dom` is 1, `rx_open` is 0 and `bus_ok` is 1. In every other case `rxd_out` is 1: this covers open bus inputs and no bus power.
- R6: `bus_pwr_n` is active low: 0 means bus power is present and 1 means it is absent.
- R7: `bus_pwr_n` falls at the ON_US × CLK_KHZ / 1000-th consecutive rising edge (300 by default) at which `bus_ok` is sampled 1 while the flag is high.
- R8: `bus_pwr_n` rises at the OFF_US × CLK_KHZ / 1000-th consecutive rising edge (10000 by default) at which `bus_ok` is sampled 0 while the flag is low.
- R9: A single sample of `bus_ok` back at its settled level restarts the running delay from zero.
- R10: When `temp_code` (unsigned, in °C) is at or above SHUT_C (default 150), `drv_en` and `drv_dom` are 0 one cycle later. `rxd_out` keeps following R5.
- R11: After a cutoff, the driver stays off while `temp_code` is above RESUME_C (default 140). It is re-enabled one cycle after a sample at or below RESUME_C.
- R12: Synchronous reset gives `drv_en` = 0, `drv_dom` = 0, `rxd_out` = 1, `bus_pwr_n` = 1, and leaves the thermal cutoff inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| txd_in | input | 1 | Transmit bit, where 0 requests a dominant bus |
| txd_float | input | 1 | Transmit bit is undriven (1 = floating) |
| logic_ok | input | 1 | Logic-side supply present |
| bus_ok | input | 1 | Bus-side supply present |
| rx_dom | input | 1 | Receive comparator sees a dominant differential |
| rx_open | input | 1 | Bus inputs detected open |
| temp_code | input | TEMP_W | Die temperature in whole °C, unsigned |
| drv_en | output | 1 | Line driver allowed to operate |
| drv_dom | output | 1 | Line driver pulls the bus dominant |
| rxd_out | output | 1 | Receive bit, where 0 means dominant |
| bus_pwr_n | output | 1 | Bus power present, active low |

## Verification
The bench walks the temperature through the hysteresis band: 150, 145, 141, 140, 149, 150 and then back down. A design that used a single threshold, or that compared with the wrong inclusive bound, would turn the driver back on at 145 or 141, or would keep it off at 140. Each supply delay is interrupted by a one-sample glitch well short of its limit. A design that paused the count instead of restarting it would move the status flag too early, and a design that ignored the glitch would also fail. The bench checks the exact edge at which the flag moves, so an off-by-one count in either direction is caught. Cutoff is checked while the receive comparator toggles, which catches a design that silences the receive path along with the driver.

// File: rtl/txsup_pkg.sv
package txsup_pkg;

    typedef enum logic {
        PG_ABSENT  = 1'b0,
        PG_PRESENT = 1'b1
    } pg_state_t;

    typedef struct packed {
        logic txd;
        logic floating;
        logic logic_ok;
        logic bus_ok;
    } tx_req_t;

    typedef struct packed {
        logic en;
        logic dom;
    } drv_cmd_t;

    typedef struct packed {
        logic dom;
        logic open;
    } rx_sense_t;

    function automatic int unsigned us_to_cycles(input int unsigned khz, input int unsigned us);
        return (khz * us) / 1000;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/txsup_pwr_seq.sv
module txsup_pwr_seq
    import txsup_pkg::*;
#(
    parameter int unsigned ON_CYC  = 300,
    parameter int unsigned OFF_CYC = 10000,
    parameter int unsigned CNT_W   = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_ok,
    output logic bus_pwr_n
);

    localparam logic [CNT_W-1:0] ON_LAST  = CNT_W'(ON_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYC - 1);

    pg_state_t        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             differs;

    assign differs = bus_ok != (st_q == PG_PRESENT);
    assign last    = (st_q == PG_PRESENT) ? OFF_LAST : ON_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PG_ABSENT;
            cnt_q <= '0;
        end else if (!differs) begin
            cnt_q <= '0;
        end else if (cnt_q == last) begin
            st_q  <= (st_q == PG_PRESENT) ? PG_ABSENT : PG_PRESENT;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bus_pwr_n = (st_q != PG_PRESENT);

    AST_PG_FALL_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_pwr_n) |-> $past(bus_ok)); // R7
    AST_PG_RISE_NEEDS_LOSS: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_pwr_n) |-> !$past(bus_ok)); // R8
    AST_PG_STEADY_WHEN_MATCHED: assert property (@(posedge clk) disable iff (rst)
        (bus_ok == !bus_pwr_n) |=> $stable(bus_pwr_n)); // R9

endmodule

// File: rtl/txsup_thermal.sv
module txsup_thermal #(
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned SHUT_C   = 150,
    parameter int unsigned RESUME_C = 140
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot_nxt
);

    localparam logic [TEMP_W-1:0] SHUT_T   = TEMP_W'(SHUT_C);
    localparam logic [TEMP_W-1:0] RESUME_T = TEMP_W'(RESUME_C);

    logic hot_q;

    always_comb begin
        hot_nxt = hot_q;
        if (temp_code >= SHUT_T) begin
            hot_nxt = 1'b1;
        end else if (temp_code <= RESUME_T) begin
            hot_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hot_q <= 1'b0;
        end else begin
            hot_q <= hot_nxt;
        end
    end

    AST_THERM_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (rst)
        (hot_q && (temp_code > RESUME_T)) |=> hot_q); // R11
    AST_THERM_COOL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (temp_code <= RESUME_T) |=> !hot_q); // R11

endmodule

// File: rtl/txsup_path.sv
module txsup_path
    import txsup_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tx_req_t   req,
    input  rx_sense_t sense,
    input  logic      hot,
    output drv_cmd_t  cmd,
    output logic      rxd_out
);

    drv_cmd_t cmd_d;
    logic     rxd_d;

    always_comb begin
        cmd_d.en  = req.logic_ok && req.bus_ok && !hot;
        cmd_d.dom = cmd_d.en && !req.floating && !req.txd;
        rxd_d     = !(req.bus_ok && !sense.open && sense.dom);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd     <= '0;
            rxd_out <= 1'b1;
        end else begin
            cmd     <= cmd_d;
            rxd_out <= rxd_d;
        end
    end

    AST_OPEN_READS_RECESSIVE: assert property (@(posedge clk) disable iff (rst)
        sense.open |=> rxd_out); // R5

endmodule

// File: rtl/txsup_top.sv
module txsup_top
    import txsup_pkg::*;
#(
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned SHUT_C   = 150,
    parameter int unsigned RESUME_C = 140,
    parameter int unsigned CLK_KHZ  = 1000,
    parameter int unsigned ON_US    = 300,
    parameter int unsigned OFF_US   = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txd_in,
    input  logic              txd_float,
    input  logic              logic_ok,
    input  logic              bus_ok,
    input  logic              rx_dom,
    input  logic              rx_open,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              drv_en,
    output logic              drv_dom,
    output logic              rxd_out,
    output logic              bus_pwr_n
);

    localparam int unsigned ON_CYC  = us_to_cycles(CLK_KHZ, ON_US);
    localparam int unsigned OFF_CYC = us_to_cycles(CLK_KHZ, OFF_US);
    localparam int unsigned CNT_W   = $clog2(max_u(ON_CYC, OFF_CYC) + 1);
    localparam logic [TEMP_W-1:0] SHUT_T = TEMP_W'(SHUT_C);

    tx_req_t   req;
    rx_sense_t sense;
    drv_cmd_t  cmd;
    logic      hot;

    assign req   = '{txd: txd_in, floating: txd_float, logic_ok: logic_ok, bus_ok: bus_ok};
    assign sense = '{dom: rx_dom, open: rx_open};

    txsup_thermal #(
        .TEMP_W   (TEMP_W),
        .SHUT_C   (SHUT_C),
        .RESUME_C (RESUME_C)
    ) u_thermal (
        .clk       (clk),
        .rst       (rst),
        .temp_code (temp_code),
        .hot_nxt   (hot)
    );

    txsup_path u_path (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .sense   (sense),
        .hot     (hot),
        .cmd     (cmd),
        .rxd_out (rxd_out)
    );

    txsup_pwr_seq #(
        .ON_CYC  (ON_CYC),
        .OFF_CYC (OFF_CYC),
        .CNT_W   (CNT_W)
    ) u_pwr_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_ok    (bus_ok),
        .bus_pwr_n (bus_pwr_n)
    );

    assign drv_en  = cmd.en;
    assign drv_dom = cmd.dom;

    AST_DOM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        drv_dom |-> drv_en); // R2
    AST_NO_LOGIC_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !logic_ok |=> !drv_en); // R3
    AST_NO_BUS_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !bus_ok |=> (!drv_en && rxd_out)); // R4
    AST_HOT_CUTS_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (temp_code >= SHUT_T) |=> !drv_en); // R10

endmodule

// File: tb/txsup_top_tb_top.sv
module txsup_top_tb_top;

    localparam int CLK_PER = 10;
    localparam int ON_CYC  = 300;
    localparam int OFF_CYC = 10000;
    localparam int SHUT    = 150;
    localparam int RESUME  = 140;

    typedef struct packed {
        logic en;
        logic dom;
        logic rxd;
        logic pwr_n;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txd_in = 1'b1, txd_float = 1'b0, logic_ok = 1'b1, bus_ok = 1'b1;
    logic       rx_dom = 1'b0, rx_open = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic       drv_en, drv_dom, rxd_out, bus_pwr_n;

    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    exp_t sb_q[$];

    bit m_hot = 0;
    bit m_st = 0;
    int m_cnt = 0;

    always #(CLK_PER/2) clk = ~clk;

    txsup_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .txd_in    (txd_in),
        .txd_float (txd_float),
        .logic_ok  (logic_ok),
        .bus_ok    (bus_ok),
        .rx_dom    (rx_dom),
        .rx_open   (rx_open),
        .temp_code (temp_code),
        .drv_en    (drv_en),
        .drv_dom   (drv_dom),
        .rxd_out   (rxd_out),
        .bus_pwr_n (bus_pwr_n)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // Driver: at a falling edge, model the sampled inputs and queue the result
    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            int lim;
            if (temp_code >= SHUT) m_hot = 1;
            else if (temp_code <= RESUME) m_hot = 0;
            e.en  = logic_ok && bus_ok && !m_hot;
            e.dom = e.en && !txd_float && !txd_in;
            e.rxd = !(bus_ok && !rx_open && rx_dom);
            lim = m_st ? OFF_CYC : ON_CYC;
            if (bus_ok == m_st) m_cnt = 0;
            else if (m_cnt == lim - 1) begin m_st = !m_st; m_cnt = 0; end
            else m_cnt++;
            e.pwr_n = !m_st;
            sb_q.push_back(e);
            @(negedge clk);
        end
    endtask

    // Monitor: compare a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PER/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check("R1/R3/R4/R10/R11 drv_en", drv_en, e.en);
                check("R1/R2 drv_dom", drv_dom, e.dom);
                check("R5 rxd_out", rxd_out, e.rxd);
                check("R6/R7/R8/R9 bus_pwr_n", bus_pwr_n, e.pwr_n);
            end
        end
    end

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state, R6 flag released
        check("R12 drv_en", drv_en, 1'b0);
        check("R12 drv_dom", drv_dom, 1'b0);
        check("R12 rxd_out", rxd_out, 1'b1);
        check("R12/R6 bus_pwr_n", bus_pwr_n, 1'b1);
        rst = 1'b0;

        // R1 / R2 transmit patterns
        txd_in = 0; tick(2);
        txd_in = 1; tick(1);
        txd_in = 0; tick(1);
        txd_float = 1; tick(2);
        txd_float = 0; tick(1);
        // R3 logic supply missing
        logic_ok = 0; tick(2);
        txd_in = 1; tick(1);
        logic_ok = 1; txd_in = 0; tick(1);
        // R5 receive patterns
        rx_dom = 1; tick(2);
        rx_open = 1; tick(1);
        rx_open = 0; tick(1);
        rx_dom = 0; tick(1);
        // R7 power flag asserts after the on delay
        tick(300);
        // R10 / R11 thermal hysteresis with receive toggling
        temp_code = 8'd150; rx_dom = 1; tick(2);
        temp_code = 8'd145; rx_dom = 0; tick(2);
        temp_code = 8'd141; rx_dom = 1; tick(2);
        temp_code = 8'd140; tick(2);
        temp_code = 8'd149; rx_dom = 0; tick(2);
        temp_code = 8'd150; tick(2);
        temp_code = 8'd100; tick(2);
        temp_code = 8'd255; tick(1);
        temp_code = 8'd25; tick(1);
        // R4 bus supply lost; R9 glitch restarts the off delay; R8 release
        bus_ok = 0; rx_dom = 1; tick(9000);
        bus_ok = 1; tick(1);
        bus_ok = 0; tick(10005);
        // R9 glitch restarts the on delay; R7 assert
        bus_ok = 1; tick(200);
        bus_ok = 0; tick(1);
        bus_ok = 1; tick(305);
        txd_in = 0; rx_dom = 0; tick(3);
        tick(0);
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule